// File: doc/BRIEF.md
# Auto-Baud Rate Detector

This block watches the receive line of a UART and measures the first start bit that arrives after software turns detection on. It counts reference-clock cycles from the falling edge to the next rising edge. It publishes that count in a read-only count register and turns it into a baud divisor for a UART core that oversamples by 16.

Four control bits set how the block behaves: enable, lock-interrupt enable, self-program and formula select. The count is published whenever a measurement completes. With self-program at 0, software reads the count and programs the divisor itself. With self-program at 1, the block writes the low and then the high divisor-latch byte itself. That divisor is either the count divided by 16, rounded to nearest, or the nearest entry of a fixed table of standard rates.

Pulses shorter than a minimum width are discarded as glitches. Each enable yields one measurement. Detection is held off while the UART runs in slow infrared mode.

Top module: `autobaud_detector`

## Requirements
- R1: After reset the control bits, the count register and the lock interrupt are all 0, and no divisor-latch write is issued.
- R2: A write through the control port stores four bits, readable on `ctrl_o`: bit 0 enable, bit 1 lock-interrupt enable, bit 2 self-program, bit 3 formula select (1 = formula, 0 = table).
- R3: The count register receives the number of clock cycles the line was sampled low during the measured start bit, whatever the self-program bit is.
- R4: A low pulse shorter than MIN_CNT cycles leaves the count register unchanged and issues no divisor write, and the block keeps waiting for a valid start bit.
- R5: The cycle counter saturates at 2^CNT_W-1 instead of wrapping.
- R6: The lock interrupt rises only after a measurement completes with enable and lock-interrupt enable both set.
- R7: Reading the interrupt identification (`iid_rd_i`) clears the lock interrupt. Clearing enable also clears it.
- R8: Only the first valid start bit after enable rises is measured. Later pulses are ignored until enable goes to 0 and back to 1, and no measurement happens while enable is 0.
- R9: With self-program at 0, no divisor-latch write is issued.
- R10: With self-program at 1 and formula select at 1, the divisor is round(count/16). The low byte is written in the cycle after completion and the high byte in the cycle after that.
- R11: With self-program at 1 and formula select at 0, the divisor is the table entry closest to round(count/16). The table holds the divisors for 1200, 2400, 4800, 9600, 19200, 38400, 57600 and 115200 baud at REF_HZ, and an exact tie picks the slower rate.
- R12: While `sir_mode_i` is high, no measurement starts or completes, and a measurement in progress is abandoned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | UART receive line (idle high) |
| sir_mode_i | input | 1 | High while the UART is in slow infrared mode |
| cfg_we_i | input | 1 | Control register write strobe |
| cfg_wdata_i | input | 4 | Control register write data |
| iid_rd_i | input | 1 | Interrupt identification read strobe |
| ctrl_o | output | 4 | Control register contents |
| count_o | output | CNT_W | Last accepted start-bit width in cycles |
| lock_irq_o | output | 1 | Auto-baud lock interrupt |
| dll_we_o | output | 1 | Divisor latch low-byte write strobe |
| dlh_we_o | output | 1 | Divisor latch high-byte write strobe |
| dl_data_o | output | 8 | Divisor byte being written |

## Verification
The bench builds the block with CNT_W = 14 and leaves REF_HZ and MIN_CNT at their defaults. At that width, a pulse of about seventeen thousand cycles reaches the saturation point. The resulting divisor of 1024 needs a nonzero high byte, which tests the second latch write. The counter range also covers every table entry, so rounding to the slowest rate and the tie between neighbouring rates can both be driven.

// File: rtl/abr_pkg.sv
package abr_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_ARM, ST_MEAS, ST_DONE} abr_state_e;
  typedef enum logic [1:0] {WR_IDLE, WR_LO, WR_HI} abr_wr_e;

  localparam int ABR_NUM_RATES = 8;

  // Standard rate by index, slowest first.
  function automatic int unsigned abr_rate(int idx);
    case (idx)
      0, 1, 2, 3, 4, 5: return 32'd1200 << idx;
      6:                return 32'd57600;
      default:          return 32'd115200;
    endcase
  endfunction

  // One bit spans 16 oversampling periods: divisor = count/16, rounded.
  function automatic int unsigned abr_formula(int unsigned cnt);
    return (cnt + 32'd8) >> 4;
  endfunction

  // Closest table divisor; ties keep the slower (larger) divisor.
  function automatic int unsigned abr_snap(int unsigned d, int unsigned ref_hz);
    int unsigned best, best_gap, cand, gap;
    best     = ref_hz / (32'd16 * abr_rate(0));
    best_gap = (d > best) ? d - best : best - d;
    for (int i = 1; i < ABR_NUM_RATES; i++) begin
      cand = ref_hz / (32'd16 * abr_rate(i));
      gap  = (d > cand) ? d - cand : cand - d;
      if (gap < best_gap) begin
        best     = cand;
        best_gap = gap;
      end
    end
    return best;
  endfunction

endpackage

// File: rtl/abr_line_sync.sv
module abr_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_i,
  output logic fall_o,
  output logic rise_o
);
  // sh[STAGES-1] is the synchronized level, sh[STAGES] its previous value.
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '1;
    else         sh_q <= {sh_q[STAGES-1:0], rx_i};
  end

  assign fall_o =  sh_q[STAGES] & ~sh_q[STAGES-1];
  assign rise_o = ~sh_q[STAGES] &  sh_q[STAGES-1];
endmodule

// File: rtl/abr_measure.sv
module abr_measure
  import abr_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int MIN_CNT = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             block_i,
  input  logic             fall_i,
  input  logic             rise_i,
  output logic             done_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_MIN = CNT_W'(MIN_CNT);

  abr_state_e       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run;

  assign run = enable_i & ~block_i;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    done_o = 1'b0;
    unique case (st_q)
      ST_IDLE: if (run) st_d = ST_ARM;
      ST_ARM: begin
        if (!run) st_d = ST_IDLE;
        else if (fall_i) begin
          st_d  = ST_MEAS;
          cnt_d = CNT_W'(1);
        end
      end
      ST_MEAS: begin
        if (!run) st_d = ST_IDLE;
        else if (rise_i) begin
          if (cnt_q >= CNT_MIN) begin
            done_o = 1'b1;
            st_d   = ST_DONE;
          end else begin
            st_d = ST_ARM;
          end
        end else if (cnt_q != CNT_MAX) begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_DONE: if (!enable_i) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/abr_dl_writer.sv
module abr_dl_writer
  import abr_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic [15:0] div_i,
  output logic        dll_we_o,
  output logic        dlh_we_o,
  output logic [7:0]  data_o
);
  abr_wr_e     st_q;
  logic [15:0] div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= WR_IDLE;
      div_q <= '0;
    end else if (start_i) begin
      st_q  <= WR_LO;
      div_q <= div_i;
    end else begin
      unique case (st_q)
        WR_LO:   st_q <= WR_HI;
        WR_HI:   st_q <= WR_IDLE;
        default: st_q <= WR_IDLE;
      endcase
    end
  end

  assign dll_we_o = (st_q == WR_LO);
  assign dlh_we_o = (st_q == WR_HI);
  assign data_o   = (st_q == WR_HI) ? div_q[15:8] : div_q[7:0];
endmodule

// File: rtl/autobaud_detector.sv
module autobaud_detector
  import abr_pkg::*;
#(
  parameter int unsigned REF_HZ      = 14745600,
  parameter int          CNT_W       = 16,
  parameter int          MIN_CNT     = 8,
  parameter int          SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_i,
  input  logic             sir_mode_i,
  input  logic             cfg_we_i,
  input  logic [3:0]       cfg_wdata_i,
  input  logic             iid_rd_i,
  output logic [3:0]       ctrl_o,
  output logic [CNT_W-1:0] count_o,
  output logic             lock_irq_o,
  output logic             dll_we_o,
  output logic             dlh_we_o,
  output logic [7:0]       dl_data_o
);
  localparam int CTL_EN = 0, CTL_IE = 1, CTL_SELF = 2, CTL_FORM = 3;

  logic [3:0]       ctrl_q;
  logic [CNT_W-1:0] count_q;
  logic             irq_q;

  // Named internal events, observed by the checker.
  logic             line_fall, line_rise;
  logic             meas_done;
  logic [CNT_W-1:0] meas_cnt;
  logic             wr_start;
  int unsigned      div_formula, div_table;
  logic [15:0]      div_sel;

  abr_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rx_i   (rx_i),
    .fall_o (line_fall),
    .rise_o (line_rise)
  );

  abr_measure #(.CNT_W(CNT_W), .MIN_CNT(MIN_CNT)) u_meas (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .enable_i (ctrl_q[CTL_EN]),
    .block_i  (sir_mode_i),
    .fall_i   (line_fall),
    .rise_i   (line_rise),
    .done_o   (meas_done),
    .cnt_o    (meas_cnt)
  );

  always_comb begin
    div_formula = abr_formula(32'(meas_cnt));
    div_table   = abr_snap(div_formula, REF_HZ);
    div_sel     = ctrl_q[CTL_FORM] ? 16'(div_formula) : 16'(div_table);
  end

  assign wr_start = meas_done & ctrl_q[CTL_SELF];

  abr_dl_writer u_wr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (wr_start),
    .div_i    (div_sel),
    .dll_we_o (dll_we_o),
    .dlh_we_o (dlh_we_o),
    .data_o   (dl_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      count_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (cfg_we_i) ctrl_q <= cfg_wdata_i;
      if (meas_done) count_q <= meas_cnt;
      if (meas_done && ctrl_q[CTL_IE]) irq_q <= 1'b1;
      else if (iid_rd_i || !ctrl_q[CTL_EN]) irq_q <= 1'b0;
    end
  end

  assign ctrl_o     = ctrl_q;
  assign count_o    = count_q;
  assign lock_irq_o = irq_q;
endmodule

// File: rtl/abr_checker.sv
module abr_checker #(
  parameter int CNT_W   = 16,
  parameter int MIN_CNT = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sir_mode_i,
  input logic             iid_rd_i,
  input logic [3:0]       ctrl_o,
  input logic [CNT_W-1:0] count_o,
  input logic             lock_irq_o,
  input logic             dll_we_o,
  input logic             dlh_we_o,
  input logic             meas_done,
  input logic [CNT_W-1:0] meas_cnt
);
  assert_count_publish_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    meas_done |=> count_o == $past(meas_cnt));

  assert_min_width_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    meas_done |-> meas_cnt >= CNT_W'(MIN_CNT));

  assert_irq_source_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_irq_o) |-> $past(meas_done && ctrl_o[1]));

  assert_irq_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iid_rd_i && !meas_done) |=> !lock_irq_o);

  assert_write_needs_self_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dll_we_o) |-> $past(meas_done && ctrl_o[2]));

  assert_low_then_high_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dll_we_o |=> dlh_we_o);

  assert_high_after_low_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dlh_we_o |-> $past(dll_we_o));

  assert_one_strobe_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({dll_we_o, dlh_we_o}));

  assert_done_gated_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    meas_done |-> (!sir_mode_i && ctrl_o[0]));
endmodule

bind autobaud_detector abr_checker #(.CNT_W(CNT_W), .MIN_CNT(MIN_CNT)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sir_mode_i (sir_mode_i),
  .iid_rd_i   (iid_rd_i),
  .ctrl_o     (ctrl_o),
  .count_o    (count_o),
  .lock_irq_o (lock_irq_o),
  .dll_we_o   (dll_we_o),
  .dlh_we_o   (dlh_we_o),
  .meas_done  (meas_done),
  .meas_cnt   (meas_cnt)
);

// File: tb/autobaud_detector_tb_top.sv
module autobaud_detector_tb_top;
  localparam int CNT_W  = 14;
  localparam int MAXC   = (1 << CNT_W) - 1;
  localparam int REF_HZ = 14745600;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic             rst_n = 1'b0;
  logic             rx = 1'b1, sir = 1'b0, cfg_we = 1'b0, iid = 1'b0;
  logic [3:0]       cfg_wdata = '0;
  logic [3:0]       ctrl;
  logic [CNT_W-1:0] count;
  logic             irq, dll_we, dlh_we;
  logic [7:0]       dl_data;

  autobaud_detector #(.CNT_W(CNT_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .rx_i(rx), .sir_mode_i(sir),
    .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata), .iid_rd_i(iid),
    .ctrl_o(ctrl), .count_o(count), .lock_irq_o(irq),
    .dll_we_o(dll_we), .dlh_we_o(dlh_we), .dl_data_o(dl_data)
  );

  int n_checks = 0, n_fail = 0;

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Divisor the requirements call for, worked out independently.
  function automatic int want_div(int c, bit formula);
    int q, best, bgap, dv, gap;
    int rl[8] = '{115200, 57600, 38400, 19200, 9600, 4800, 2400, 1200};
    q = c / 16;
    if (c % 16 >= 8) q++;
    if (formula) return q;
    best = -1; bgap = 0;
    foreach (rl[i]) begin
      dv  = REF_HZ / 16 / rl[i];
      gap = (q > dv) ? q - dv : dv - q;
      if (best < 0 || gap <= bgap) begin best = dv; bgap = gap; end
    end
    return best;
  endfunction

  // Behavioural reference, advanced on every rising edge.
  bit   hist[$] = '{1, 1, 1};
  int   m_state = 0, m_cnt = 0, m_count = 0, m_wr = 0, m_div = 0;
  bit   m_irq = 0;
  bit [3:0] m_ctrl = 0;

  always @(posedge clk) begin
    bit cur, old, en, done;
    if (!rst_n) begin
      hist = '{1, 1, 1};
      m_state = 0; m_cnt = 0; m_count = 0; m_wr = 0; m_div = 0; m_irq = 0; m_ctrl = 0;
    end else begin
      cur = hist[1]; old = hist[2]; en = m_ctrl[0]; done = 0;
      case (m_state)
        0: if (en && !sir) m_state = 1;
        1: if (!en || sir) m_state = 0;
           else if (old && !cur) begin m_state = 2; m_cnt = 1; end
        2: if (!en || sir) m_state = 0;
           else if (cur) begin
             if (m_cnt >= 8) begin done = 1; m_state = 3; end else m_state = 1;
           end else if (m_cnt < MAXC) m_cnt++;
        default: if (!en) m_state = 0;
      endcase
      if (m_wr == 1) m_wr = 2; else if (m_wr == 2) m_wr = 0;
      if (done && m_ctrl[2]) begin m_wr = 1; m_div = want_div(m_cnt, m_ctrl[3]); end
      if (done) m_count = m_cnt;
      if (done && m_ctrl[1]) m_irq = 1;
      else if (iid || !en) m_irq = 0;
      if (cfg_we) m_ctrl = cfg_wdata;
      hist.push_front(rx);
      void'(hist.pop_back());
    end
  end

  // Per-cycle comparison and divisor-latch capture.
  int wr_seen = 0, lo_b = 0, hi_b = 0;
  always @(negedge clk) begin
    check("R2 ctrl", int'(ctrl), int'(m_ctrl));
    check("R3 count", int'(count), m_count);
    check("R6 irq", int'(irq), int'(m_irq));
    check("R10 dll_we", int'(dll_we), int'(m_wr == 1));
    check("R10 dlh_we", int'(dlh_we), int'(m_wr == 2));
    if (m_wr == 1) check("R10 low byte", int'(dl_data), m_div & 255);
    if (m_wr == 2) check("R10 high byte", int'(dl_data), (m_div >> 8) & 255);
    if (dll_we) begin lo_b = dl_data; wr_seen++; end
    if (dlh_we) hi_b = dl_data;
  end

  task automatic wr_ctrl(logic [3:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic pulse(int n);
    @(negedge clk); rx = 1'b0;
    repeat (n) @(negedge clk);
    rx = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic iid_read();
    @(negedge clk); iid = 1'b1;
    @(negedge clk); iid = 1'b0;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int w0;
    repeat (4) @(negedge clk);
    check("R1 ctrl reset", int'(ctrl), 0);
    check("R1 count reset", int'(count), 0);
    check("R1 irq reset", int'(irq), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 no writes", wr_seen, 0);

    pulse(100);                      // disabled: nothing measured
    check("R8 disabled", int'(count), 0);

    wr_ctrl(4'b0011);                // enable + interrupt, no self-program
    check("R2 ctrl readback", int'(ctrl), 3);
    pulse(100);
    check("R3 width 100", int'(count), 100);
    check("R6 irq raised", int'(irq), 1);
    check("R9 no latch write", wr_seen, 0);
    iid_read();
    check("R7 irq cleared", int'(irq), 0);
    pulse(200);
    check("R8 second pulse ignored", int'(count), 100);

    wr_ctrl(4'b0000);
    wr_ctrl(4'b1101);                // enable, self-program, formula
    pulse(5);
    check("R4 glitch count", int'(count), 100);
    check("R4 glitch no write", wr_seen, 0);
    pulse(1000);
    check("R3 width 1000", int'(count), 1000);
    check("R10 formula low", lo_b, 63);
    check("R10 formula high", hi_b, 0);
    check("R6 irq off when disabled", int'(irq), 0);

    wr_ctrl(4'b0000);
    wr_ctrl(4'b0101);                // table mode
    pulse(1500);
    check("R11 snap 94->96", lo_b, 96);
    wr_ctrl(4'b0000);
    wr_ctrl(4'b0101);
    pulse(1144);
    check("R11 tie 72->96", lo_b, 96);
    check("R11 tie high", hi_b, 0);

    w0 = wr_seen;
    wr_ctrl(4'b0000);
    sir = 1'b1;
    wr_ctrl(4'b1101);
    pulse(300);
    check("R12 held off", int'(count), 1144);
    sir = 1'b0;
    repeat (2) @(negedge clk);
    rx = 1'b0;
    repeat (50) @(negedge clk);
    sir = 1'b1;
    repeat (50) @(negedge clk);
    rx = 1'b1;
    repeat (8) @(negedge clk);
    sir = 1'b0;
    check("R12 aborted", int'(count), 1144);
    check("R12 no write", wr_seen, w0);

    wr_ctrl(4'b0000);
    wr_ctrl(4'b1101);
    pulse(17000);
    check("R5 saturated", int'(count), MAXC);
    check("R5 sat low byte", lo_b, 0);
    check("R5 sat high byte", hi_b, 4);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule